// File: doc/BRIEF.md
# Branch Trace History Queue

This block keeps a short record of the most recent taken branches for on-chip debug. Each branch event writes one entry into two paired queues of eight entries. The source side holds the last address fetched before the branch and a 3-bit decode pointer. The destination side holds the fetch address of the branch target and a flag that marks the entry as valid. The two sides share one write pointer, so both sides of an entry always describe the same branch.

Software sees the oldest entry through two 32-bit read-only views. Reading the destination view pops that entry and clears its flag. Reading the source view has no side effect. When the queue is full, a new branch overwrites the oldest entry. Either of two active-low resets (power-on and manual) clears every flag and both pointers. Neither reset touches the stored addresses.

The pointer field is stored exactly as it arrives. Software turns it into an instruction-buffer number: an even value is the buffer number itself, and an odd value means buffer value+2.

Top module: `branch_trace_queue`

## Requirements
- R1: When `branchValid` is high at a clock edge, `srcAddr`, `decodePtr` and `dstAddr` are written together into the tail entry of the queue.
- R2: `dstData` is laid out as follows. Bit 31 is the flag of the oldest entry: 1 means valid and 0 means the queue is empty. Bits 30:28 read 0. Bits 27:0 hold that entry's target address.
- R3: `srcData` is laid out as follows. Bit 31 reads 0. Bits 30:28 hold the stored decode pointer unchanged: an even value names the buffer, and an odd value names buffer value+2. Bits 27:0 hold the source fetch address.
- R4: A `dstRead` while the flag is 1 pops the oldest entry. From the next cycle both views show the next-oldest entry.
- R5: A `dstRead` while the queue is empty has no effect, and the flag stays 0.
- R6: `srcRead` never changes the queue contents or the order.
- R7: A branch that arrives when eight entries are held discards the oldest entry.
- R8: When a branch and a `dstRead` come in the same cycle, the head is popped first and the new entry then enters the tail.
- R9: A low on `porRstN` clears every flag, so the queue reads as empty.
- R10: A low on `manRstN` also clears every flag, and the next branch recorded becomes the head entry.
- R11: Entries are read back oldest-first, in the order their branches occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, asynchronous, active low |
| manRstN | input | 1 | Manual reset, asynchronous, active low |
| branchValid | input | 1 | Branch taken in this cycle |
| srcAddr | input | 28 | Last fetch address before the branch |
| decodePtr | input | 3 | Instruction decode pointer |
| dstAddr | input | 28 | Branch target fetch address |
| srcRead | input | 1 | Read strobe for the source view |
| dstRead | input | 1 | Read strobe for the destination view (pops) |
| srcData | output | 32 | Source view of the oldest entry |
| dstData | output | 32 | Destination view of the oldest entry |

## Verification
The assertions assume that each read strobe lasts one cycle per read. They also assume that the address, pointer and target inputs are valid whenever `branchValid` is high.

The checker counts occupancy on its own from the strobes. It takes for granted that the resets are the only other thing that can empty the queue.

The stimulus meets these assumptions:
- Every strobe is driven for exactly one cycle.
- Inputs change just after a clock edge.
- A reset is asserted only while no strobe is high.

// File: rtl/btq_pkg.sv
package btq_pkg;
  localparam int ADDR_W = 28;
  localparam int PTR_W  = 3;
  localparam int REG_W  = 1 + PTR_W + ADDR_W;

  typedef struct packed {
    logic push;
    logic [7:0] wrIdx;
    logic [7:0] rdIdx;
    logic headValid;
  } btqStrobes_t;
endpackage

// File: rtl/btq_ctrl.sv
module btq_ctrl #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic branchValid,
  input  logic dstRead,
  output btq_pkg::btqStrobes_t strobes
);
  localparam int IW = $clog2(DEPTH);

  logic [IW-1:0] wrPtr, rdPtr;
  logic [DEPTH-1:0] valid;
  logic doPop, fullPush;

  function automatic logic [IW-1:0] nextIdx(input logic [IW-1:0] idx);
    return (idx == IW'(DEPTH - 1)) ? '0 : idx + 1'b1;
  endfunction

  assign doPop    = dstRead && valid[rdPtr];
  // The write slot holds a valid entry only when every slot is full.
  assign fullPush = branchValid && valid[wrPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      valid <= '0;
    end else begin
      if (doPop) valid[rdPtr] <= 1'b0;
      if (branchValid) begin
        valid[wrPtr] <= 1'b1;
        wrPtr <= nextIdx(wrPtr);
      end
      if (doPop || fullPush) rdPtr <= nextIdx(rdPtr);
    end
  end

  always_comb begin
    strobes = '0;
    strobes.push = branchValid;
    strobes.wrIdx = 8'(wrPtr);
    strobes.rdIdx = 8'(rdPtr);
    strobes.headValid = valid[rdPtr];
  end
endmodule

// File: rtl/btq_datapath.sv
module btq_datapath #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  btq_pkg::btqStrobes_t strobes,
  input  logic [btq_pkg::ADDR_W-1:0] srcAddr,
  input  logic [btq_pkg::PTR_W-1:0]  decodePtr,
  input  logic [btq_pkg::ADDR_W-1:0] dstAddr,
  output logic [btq_pkg::REG_W-1:0]  srcData,
  output logic [btq_pkg::REG_W-1:0]  dstData
);
  import btq_pkg::*;
  localparam int IW = $clog2(DEPTH);
  localparam int SRC_W = PTR_W + ADDR_W;

  // Storage is deliberately not reset: only the flags are.
  logic [SRC_W-1:0]  srcMem [DEPTH];
  logic [ADDR_W-1:0] dstMem [DEPTH];
  logic [IW-1:0] wrIdx, rdIdx;

  assign wrIdx = strobes.wrIdx[IW-1:0];
  assign rdIdx = strobes.rdIdx[IW-1:0];

  always_ff @(posedge clk) begin
    if (strobes.push) begin
      srcMem[wrIdx] <= {decodePtr, srcAddr};
      dstMem[wrIdx] <= dstAddr;
    end
  end

  assign srcData = {1'b0, srcMem[rdIdx]};
  assign dstData = {strobes.headValid, {PTR_W{1'b0}}, dstMem[rdIdx]};
endmodule

// File: rtl/branch_trace_queue.sv
module branch_trace_queue #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        porRstN,
  input  logic        manRstN,
  input  logic        branchValid,
  input  logic [27:0] srcAddr,
  input  logic [2:0]  decodePtr,
  input  logic [27:0] dstAddr,
  input  logic        srcRead,
  input  logic        dstRead,
  output logic [31:0] srcData,
  output logic [31:0] dstData
);
  btq_pkg::btqStrobes_t strobes;
  logic rstN;
  logic unusedSrcRead;

  assign rstN = porRstN & manRstN;
  // The source view has no side effect on a read.
  assign unusedSrcRead = srcRead;

  btq_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .branchValid(branchValid),
    .dstRead(dstRead), .strobes(strobes)
  );

  btq_datapath #(.DEPTH(DEPTH)) uData (
    .clk(clk), .strobes(strobes), .srcAddr(srcAddr), .decodePtr(decodePtr),
    .dstAddr(dstAddr), .srcData(srcData), .dstData(dstData)
  );
endmodule

// File: rtl/btq_checker.sv
module btq_checker #(
  parameter int DEPTH = 8
) (
  input logic        clk,
  input logic        porRstN,
  input logic        manRstN,
  input logic        branchValid,
  input logic        srcRead,
  input logic        dstRead,
  input logic [31:0] srcData,
  input logic [31:0] dstData
);
  localparam int CW = $clog2(DEPTH + 1);
  logic rstN;
  logic [CW-1:0] occ;
  logic popOk;

  assign rstN  = porRstN & manRstN;
  assign popOk = dstRead && (occ != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) occ <= '0;
    else if (branchValid) occ <= (occ == CW'(DEPTH) && !popOk) ? occ : occ - CW'(popOk) + 1'b1;
    else occ <= occ - CW'(popOk);
  end

  // R1: a recorded branch always leaves a valid head
  assert_flag_after_push_R1: assert property (@(posedge clk) disable iff (!rstN)
    branchValid |=> dstData[31]);

  // R5: a read on an empty queue leaves it empty
  assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!dstData[31] && !branchValid) |=> !dstData[31]);

  // R6: the source read is free of side effects
  assert_src_read_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (srcRead && !dstRead && !branchValid) |=> ($stable(dstData) && $stable(srcData)));

  // R4: the flag tracks the occupancy counted from the strobes
  assert_flag_matches_occ_R4: assert property (@(posedge clk) disable iff (!rstN)
    dstData[31] == (occ != '0));
endmodule

bind branch_trace_queue btq_checker #(.DEPTH(DEPTH)) uChecker (
  .clk(clk), .porRstN(porRstN), .manRstN(manRstN), .branchValid(branchValid),
  .srcRead(srcRead), .dstRead(dstRead), .srcData(srcData), .dstData(dstData)
);

// File: tb/tb_branch_trace_queue.sv
`timescale 1ns/1ps
module tb_branch_trace_queue;
  logic clk = 1'b0;
  logic porRstN = 1'b0, manRstN = 1'b1;
  logic branchValid = 1'b0, srcRead = 1'b0, dstRead = 1'b0;
  logic [27:0] srcAddr = '0, dstAddr = '0;
  logic [2:0] decodePtr = '0;
  logic [31:0] srcData, dstData;

  int compared = 0, mismatched = 0, seqNo = 0;
  bit done = 0;
  logic [27:0] mSrc[$], mDst[$];
  logic [2:0] mPtr[$];

  always #4 clk = ~clk;

  branch_trace_queue dut (
    .clk(clk), .porRstN(porRstN), .manRstN(manRstN), .branchValid(branchValid),
    .srcAddr(srcAddr), .decodePtr(decodePtr), .dstAddr(dstAddr),
    .srcRead(srcRead), .dstRead(dstRead), .srcData(srcData), .dstData(dstData)
  );

  function automatic logic [27:0] srcOf(int s); return 28'h0100000 + 28'(s) * 28'h13; endfunction
  function automatic logic [27:0] dstOf(int s); return 28'hA000000 ^ (28'(s) * 28'h1F1); endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkHead(string tag);
    check({tag, " R2 flag"}, {31'b0, dstData[31]}, {31'b0, mDst.size() != 0});
    if (mDst.size() != 0) begin
      check({tag, " R2 dst"}, dstData, {1'b1, 3'b000, mDst[0]});
      check({tag, " R3 src"}, srcData, {1'b0, mPtr[0], mSrc[0]});
    end
  endtask

  task automatic cyc(bit b, bit sr, bit dr);
    branchValid = b; srcRead = sr; dstRead = dr;
    srcAddr = srcOf(seqNo); dstAddr = dstOf(seqNo); decodePtr = 3'(seqNo);
    @(posedge clk);
    if (dr && mDst.size() != 0) begin
      void'(mSrc.pop_front()); void'(mDst.pop_front()); void'(mPtr.pop_front());
    end
    if (b) begin
      if (mDst.size() == 8) begin
        void'(mSrc.pop_front()); void'(mDst.pop_front()); void'(mPtr.pop_front());
      end
      mSrc.push_back(srcOf(seqNo)); mDst.push_back(dstOf(seqNo)); mPtr.push_back(3'(seqNo));
      seqNo++;
    end
    #1;
    branchValid = 0; srcRead = 0; dstRead = 0;
  endtask

  task automatic doReset(bit manual);
    if (manual) manRstN = 0; else porRstN = 0;
    #20;
    manRstN = 1; porRstN = 1;
    mSrc.delete(); mDst.delete(); mPtr.delete();
    @(posedge clk); #1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    doReset(0);
    check("R9 flag after power-on reset", {31'b0, dstData[31]}, 32'd0);

    // R1 R7 R11: fill with 0..11 entries, then drain in order
    for (int n = 0; n <= 11; n++) begin
      doReset(0);
      for (int i = 0; i < n; i++) begin
        cyc(1, 0, 0);
        checkHead("R1 R7 push");
      end
      begin
        logic [31:0] s0, d0;
        s0 = srcData; d0 = dstData;
        cyc(0, 1, 0);
        check("R6 src read src view", srcData, s0);
        check("R6 src read dst view", dstData, d0);
      end
      check("R7 occupancy capped", 32'(mDst.size()), 32'((n > 8) ? 8 : n));
      while (mDst.size() != 0) begin
        cyc(0, 0, 1);
        checkHead("R4 R11 drain");
      end
      cyc(0, 0, 1);
      check("R5 empty read flag", {31'b0, dstData[31]}, 32'd0);
    end

    // R8: branch and pop together at every occupancy
    for (int k = 0; k <= 8; k++) begin
      doReset(0);
      for (int i = 0; i < k; i++) cyc(1, 0, 0);
      cyc(1, 0, 1);
      checkHead("R8 push+pop");
      check("R8 occupancy", 32'(mDst.size()), 32'((k == 0) ? 1 : k));
      while (mDst.size() != 0) begin
        cyc(0, 0, 1);
        checkHead("R8 R11 drain");
      end
    end

    // R10: manual reset clears the flags and restarts the order
    doReset(0);
    for (int i = 0; i < 5; i++) cyc(1, 0, 0);
    doReset(1);
    check("R10 flag after manual reset", {31'b0, dstData[31]}, 32'd0);
    cyc(1, 0, 0);
    checkHead("R10 new head");
    cyc(0, 0, 1);
    check("R10 single entry popped", {31'b0, dstData[31]}, 32'd0);

    // R9: power-on reset on a full queue
    for (int i = 0; i < 9; i++) cyc(1, 0, 0);
    doReset(0);
    check("R9 flag after reset of full queue", {31'b0, dstData[31]}, 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule